// File: doc/BRIEF.md
# Switchable-Width Register Access Target

This block is the byte-level transaction engine and register file of a serial-bus target. A separate bus PHY handles the electrical layer. It reports start, repeated-start and stop events as single-cycle pulses. For the address header it gives a valid pulse, an address-match flag and a direction flag. For each byte the controller writes it gives a valid pulse with the byte. For each byte the controller wants to read it gives a request pulse. The block answers every header and every written byte with an acknowledge decision, and answers each read request with a data byte.

After a write header, the first one or two bytes form the register offset, followed by data bytes. The offset width is selected by bit 2 of the control register at offset 0x30. The bit is sampled at each start or repeated start, so a write to it changes how the next transaction is parsed. The current one is not affected. The pointer auto-increments after every data byte. A region of calibration registers refuses writes until a two-byte key sequence has been written to a key register.

States of the transaction machine:
- `ST_IDLE`: no transaction.
- `ST_HDR`: waiting for the header.
- `ST_OFS_HI`: offset high byte, used in two-byte mode only.
- `ST_OFS_LO`: offset low byte, or the only offset byte in one-byte mode.
- `ST_WR`: data writes.
- `ST_RD`: data reads.
- `ST_SKIP`: the header did not match.

Transitions of the transaction machine:
- A stop moves any state to `ST_IDLE`.
- A start or repeated start moves any state to `ST_HDR`.
- In `ST_HDR`, the header moves the machine to `ST_SKIP` if unmatched, to `ST_RD` if a read, and otherwise to `ST_OFS_HI` or `ST_OFS_LO` depending on the latched width.
- Each offset byte advances `ST_OFS_HI` to `ST_OFS_LO`, and `ST_OFS_LO` to `ST_WR`.

The unlock machine has three states:
- `LK_SHUT`: locked.
- `LK_HALF`: the first key has been seen.
- `LK_OPEN`: unlocked.

Transitions of the unlock machine:
- Writing 0x73 moves it to `LK_HALF`.
- Writing 0x94 while in `LK_HALF` moves it to `LK_OPEN`.
- Any other value moves it to `LK_SHUT`.

Top module: `regacc_target`

## Requirements
- R1: After reset `ack_valid` and `rd_valid` are low, the target is in one-byte offset mode, and a read of offset 0x00 returns 0x04.
- R2: In one-byte mode one offset byte selects the register, data writes and reads auto-increment the pointer, and the pointer wraps from 0xFF to 0x00.
- R3: Bit 2 of register 0x30 (set = two-byte, clear = one-byte) is sampled only at a start or repeated start. Register 0x30 reads back as written and is reached as 0x30 in one-byte mode and 0x0030 in two-byte mode.
- R4: In two-byte mode a write is header, offset high byte, offset low byte, then data. The byte register at 0x0300 is reachable only this way.
- R5: Offsets 0x0000 and 0x0001 are read-only identification values 0x04 and 0x23; writes to them are acknowledged and discarded.
- R6: A repeated start with read direction after the offset phase reads from the latched offset; a read header with no offset phase continues from the current pointer.
- R7: In two-byte mode the pointer wraps from 0xFFFF to 0x0000.
- R8: While locked, writes to 0x40..0x6F are acknowledged but discarded; that region reads 0x00 after reset.
- R9: Writing 0x73 then 0x94 to key register 0x37 unlocks 0x40..0x6F; any other value written there restarts the sequence and relocks. The key register reads 0x00.
- R10: Unimplemented offsets read 0x00 and ignore writes.
- R11: A matched header and every offset or data byte after a write header are acknowledged (`ack`=1). An unmatched header and all bytes after it are not acknowledged and write nothing.
- R12: `rd_valid` with `rd_data` follows a read request in the read phase by exactly one cycle; `ack_valid` follows each header or written byte by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start event pulse |
| bus_rstart | input | 1 | Repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| hdr_valid | input | 1 | Address header received |
| hdr_match | input | 1 | Header address equals this target |
| hdr_read | input | 1 | Header direction is read |
| wr_valid | input | 1 | Controller-written byte valid |
| wr_byte | input | 8 | Controller-written byte |
| rd_req | input | 1 | Controller requests a read byte |
| ack_valid | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |

## Verification
The hardest case is the width switch itself. The bench writes the mode bit in one-byte mode, ends that transaction, and then sends two offset bytes 0x00, 0x30 followed by a repeated-start read. A stale width would take 0x00 as the offset, treat 0x30 as data, and read 0x23 instead of the control value. The reverse switch is driven from two-byte mode. The 16-bit wrap needs offset 0xFFFF, and the unlock sequence is first broken by a wrong key before the correct pair is sent.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR, ST_OFS_HI, ST_OFS_LO, ST_WR, ST_RD, ST_SKIP
    } xfer_st_t;

    typedef enum logic [1:0] {
        LK_SHUT, LK_HALF, LK_OPEN
    } lock_st_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/regacc_lock.sv
module regacc_lock
    import regacc_pkg::*;
#(
    parameter logic [7:0] KEY_A = 8'h73,
    parameter logic [7:0] KEY_B = 8'h94
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_data,
    output logic       open
);
    lock_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (key_we) begin
            unique case (st_q)
                LK_HALF: st_d = (key_data == KEY_B) ? LK_OPEN :
                                (key_data == KEY_A) ? LK_HALF : LK_SHUT;
                default: st_d = (key_data == KEY_A) ? LK_HALF : LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_SHUT;
        else        st_q <= st_d;
    end

    always_comb open = (st_q == LK_OPEN);
endmodule

// File: rtl/regacc_regfile.sv
module regacc_regfile
    import regacc_pkg::*;
#(
    parameter int         AW        = 16,
    parameter logic [7:0] ID0       = 8'h04,
    parameter logic [7:0] ID1       = 8'h23,
    parameter int         CTRL_OFS  = 'h30,
    parameter int         MODE_BIT  = 2,
    parameter int         KEY_OFS   = 'h37,
    parameter int         PROT_BASE = 'h40,
    parameter int         PROT_LEN  = 48,
    parameter int         EXT_OFS   = 'h300,
    parameter logic [7:0] KEY_A     = 8'h73,
    parameter logic [7:0] KEY_B     = 8'h94
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    output logic          mode_bit
);
    localparam int            PW    = (PROT_LEN > 1) ? $clog2(PROT_LEN) : 1;
    localparam logic [AW-1:0] A_ID1 = AW'(1);
    localparam logic [AW-1:0] A_CTL = AW'(CTRL_OFS);
    localparam logic [AW-1:0] A_KEY = AW'(KEY_OFS);
    localparam logic [AW-1:0] A_EXT = AW'(EXT_OFS);
    localparam logic [AW-1:0] P_LO  = AW'(PROT_BASE);
    localparam logic [AW-1:0] P_HI  = AW'(PROT_BASE + PROT_LEN);

    logic [7:0] ctrl_q, ext_q;
    logic [7:0] prot_q [PROT_LEN];
    logic       unlocked;

    function automatic logic in_prot(input logic [AW-1:0] a);
        return (a >= P_LO) && (a < P_HI);
    endfunction

    function automatic logic [PW-1:0] prot_idx(input logic [AW-1:0] a);
        logic [AW-1:0] d;
        d = a - P_LO;
        return d[PW-1:0];
    endfunction

    regacc_lock #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (we && (waddr == A_KEY)),
        .key_data (wdata),
        .open     (unlocked)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ext_q  <= '0;
        end else if (we) begin
            if (waddr == A_CTL) ctrl_q <= wdata;
            if (waddr == A_EXT) ext_q  <= wdata;
        end
    end

    for (genvar i = 0; i < PROT_LEN; i++) begin : g_prot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prot_q[i] <= '0;
            else if (we && unlocked && in_prot(waddr) && (prot_idx(waddr) == PW'(i)))
                prot_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr == '0)          rdata = ID0;
        else if (raddr == A_ID1)  rdata = ID1;
        else if (raddr == A_CTL)  rdata = ctrl_q;
        else if (raddr == A_EXT)  rdata = ext_q;
        else if (in_prot(raddr))  rdata = prot_q[prot_idx(raddr)];
    end

    always_comb mode_bit = ctrl_q[MODE_BIT];
endmodule

// File: rtl/regacc_fsm.sv
module regacc_fsm
    import regacc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start,
    input  logic          bus_rstart,
    input  logic          bus_stop,
    input  logic          hdr_valid,
    input  logic          hdr_match,
    input  logic          hdr_read,
    input  logic          wr_valid,
    input  logic [7:0]    wr_byte,
    input  logic          rd_req,
    input  logic          mode_bit,
    input  logic [7:0]    rd_word,
    output logic          ack_valid,
    output logic          ack,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          reg_we,
    output logic [AW-1:0] reg_addr,
    output logic          mode_lat,
    output xfer_st_t      state
);
    localparam int HW = AW - BYTE_W;

    xfer_st_t         st_q, st_d;
    logic [AW-1:0]    ptr_q;
    logic [HW-1:0]    ofs_hi_q;
    logic             evt, any_start;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic wide);
        logic [BYTE_W-1:0] lo;
        lo = p[BYTE_W-1:0] + 1'b1;
        return wide ? p + 1'b1 : {{HW{1'b0}}, lo};
    endfunction

    always_comb begin
        evt       = bus_start | bus_rstart | bus_stop;
        any_start = bus_start | bus_rstart;
    end

    always_comb begin
        st_d = st_q;
        if (bus_stop)       st_d = ST_IDLE;
        else if (any_start) st_d = ST_HDR;
        else begin
            unique case (st_q)
                ST_HDR:    if (hdr_valid)
                               st_d = !hdr_match ? ST_SKIP :
                                      hdr_read   ? ST_RD   :
                                      mode_lat   ? ST_OFS_HI : ST_OFS_LO;
                ST_OFS_HI: if (wr_valid) st_d = ST_OFS_LO;
                ST_OFS_LO: if (wr_valid) st_d = ST_WR;
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            ptr_q     <= '0;
            ofs_hi_q  <= '0;
            mode_lat  <= 1'b0;
        end else begin
            ack_valid <= hdr_valid | wr_valid;
            ack       <= !evt && ((hdr_valid && st_q == ST_HDR && hdr_match) ||
                                  (wr_valid && (st_q == ST_OFS_HI || st_q == ST_OFS_LO ||
                                                st_q == ST_WR)));
            rd_valid  <= 1'b0;
            if (any_start) mode_lat <= mode_bit;
            if (!evt) begin
                if (st_q == ST_OFS_HI && wr_valid) ofs_hi_q <= wr_byte[HW-1:0];
                if (st_q == ST_OFS_LO && wr_valid)
                    ptr_q <= mode_lat ? {ofs_hi_q, wr_byte} : {{HW{1'b0}}, wr_byte};
                if (st_q == ST_WR && wr_valid) ptr_q <= step(ptr_q, mode_lat);
                if (st_q == ST_RD && rd_req) begin
                    rd_data  <= rd_word;
                    rd_valid <= 1'b1;
                    ptr_q    <= step(ptr_q, mode_lat);
                end
            end
        end
    end

    always_comb begin
        reg_we   = !evt && wr_valid && (st_q == ST_WR);
        reg_addr = ptr_q;
        state    = st_q;
    end
endmodule

// File: rtl/regacc_target.sv
module regacc_target
    import regacc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int PROT_BASE = 'h40,
    parameter int PROT_LEN  = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_rstart,
    input  logic       bus_stop,
    input  logic       hdr_valid,
    input  logic       hdr_match,
    input  logic       hdr_read,
    input  logic       wr_valid,
    input  logic [7:0] wr_byte,
    input  logic       rd_req,
    output logic       ack_valid,
    output logic       ack,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    logic          reg_we, mode_bit, mode_lat;
    logic [AW-1:0] ptr;
    logic [7:0]    rd_word;
    xfer_st_t      fsm_st;

    regacc_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_rstart (bus_rstart),
        .bus_stop   (bus_stop),
        .hdr_valid  (hdr_valid),
        .hdr_match  (hdr_match),
        .hdr_read   (hdr_read),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .rd_req     (rd_req),
        .mode_bit   (mode_bit),
        .rd_word    (rd_word),
        .ack_valid  (ack_valid),
        .ack        (ack),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .reg_we     (reg_we),
        .reg_addr   (ptr),
        .mode_lat   (mode_lat),
        .state      (fsm_st)
    );

    regacc_regfile #(.AW(AW), .PROT_BASE(PROT_BASE), .PROT_LEN(PROT_LEN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (ptr),
        .wdata    (wr_byte),
        .raddr    (ptr),
        .rdata    (rd_word),
        .mode_bit (mode_bit)
    );
endmodule

// File: rtl/regacc_target_chk.sv
module regacc_target_chk
    import regacc_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_start,
    input logic          bus_rstart,
    input logic          bus_stop,
    input logic          hdr_valid,
    input logic          hdr_match,
    input logic          wr_valid,
    input logic          rd_req,
    input logic          ack_valid,
    input logic          ack,
    input logic          rd_valid,
    input logic          mode_lat,
    input logic [AW-1:0] ptr,
    input xfer_st_t      fsm_st
);
    // R3: width changes only at a start or repeated start
    a_r3_mode_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_start && !bus_rstart) |=> $stable(mode_lat));

    // R2: one-byte mode keeps the pointer within 8 bits
    a_r2_narrow_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_st == ST_WR || fsm_st == ST_RD) && !mode_lat) |-> (ptr[AW-1:8] == '0));

    // R11: unmatched header is not acknowledged
    a_r11_nack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_match) |=> (ack_valid && !ack));

    // R12: read data only after a request
    a_r12_rd_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R12: every header or written byte gets a decision
    a_r12_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid || wr_valid) |=> ack_valid);

    // R12: a read request in the read phase is served next cycle
    a_r12_rd_served: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && fsm_st == ST_RD && !bus_start && !bus_rstart && !bus_stop) |=> rd_valid);

    // R11: a stop ends the transaction
    a_r11_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (fsm_st == ST_IDLE));
endmodule

bind regacc_target regacc_target_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .bus_rstart (bus_rstart),
    .bus_stop   (bus_stop),
    .hdr_valid  (hdr_valid),
    .hdr_match  (hdr_match),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .ack_valid  (ack_valid),
    .ack        (ack),
    .rd_valid   (rd_valid),
    .mode_lat   (mode_lat),
    .ptr        (ptr),
    .fsm_st     (fsm_st)
);

// File: tb/regacc_target_test.sv
module regacc_target_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 0, bus_rstart = 0, bus_stop = 0;
    logic       hdr_valid = 0, hdr_match = 0, hdr_read = 0;
    logic       wr_valid = 0, rd_req = 0;
    logic [7:0] wr_byte = '0;
    logic       ack_valid, ack, rd_valid;
    logic [7:0] rd_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic       q_ack[$];
    string      q_ack_tag[$];
    logic [7:0] q_rd[$];
    string      q_rd_tag[$];

    always #5 clk = ~clk;

    regacc_target uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rstart(bus_rstart),
        .bus_stop(bus_stop), .hdr_valid(hdr_valid), .hdr_match(hdr_match),
        .hdr_read(hdr_read), .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req),
        .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (ack_valid) begin
                if (q_ack.size() == 0) check("R12 unexpected ack", 8'h1, 8'h0);
                else check(q_ack_tag.pop_front(), {7'b0, ack}, {7'b0, q_ack.pop_front()});
            end
            if (rd_valid) begin
                if (q_rd.size() == 0) check("R12 unexpected read", 8'h1, 8'h0);
                else check(q_rd_tag.pop_front(), rd_data, q_rd.pop_front());
            end
        end
    end

    task automatic ev_start(input bit rep);
        @(negedge clk);
        if (rep) bus_rstart = 1; else bus_start = 1;
        @(negedge clk);
        bus_start = 0; bus_rstart = 0;
    endtask

    task automatic ev_stop();
        @(negedge clk); bus_stop = 1;
        @(negedge clk); bus_stop = 0;
    endtask

    task automatic hdr(input bit m, input bit rd, input string tag);
        q_ack.push_back(m); q_ack_tag.push_back(tag);
        @(negedge clk); hdr_valid = 1; hdr_match = m; hdr_read = rd;
        @(negedge clk); hdr_valid = 0;
    endtask

    task automatic wr(input logic [7:0] b, input bit exp_ack, input string tag);
        q_ack.push_back(exp_ack); q_ack_tag.push_back(tag);
        @(negedge clk); wr_valid = 1; wr_byte = b;
        @(negedge clk); wr_valid = 0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        q_rd.push_back(exp); q_rd_tag.push_back(tag);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0;
        check("R12 rd_valid one cycle after request", {7'b0, rd_valid}, 8'h1);
    endtask

    task automatic set_ofs(input logic [15:0] o, input bit two, input string tag);
        ev_start(0);
        hdr(1, 0, tag);
        if (two) wr(o[15:8], 1, tag);
        wr(o[7:0], 1, tag);
    endtask

    task automatic wr_reg(input logic [15:0] o, input bit two, input logic [7:0] d, input string tag);
        set_ofs(o, two, tag);
        wr(d, 1, tag);
        ev_stop();
    endtask

    task automatic rd_reg(input logic [15:0] o, input bit two, input logic [7:0] e, input string tag);
        set_ofs(o, two, tag);
        ev_start(1);
        hdr(1, 1, tag);
        rd(e, tag);
        ev_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 ack_valid after reset", {7'b0, ack_valid}, 8'h0);
        check("R1 rd_valid after reset", {7'b0, rd_valid}, 8'h0);

        // R1 / R5 / R6: one-byte offset 0, repeated-start read
        set_ofs(16'h0000, 0, "R1 offset phase");
        ev_start(1);
        hdr(1, 1, "R6 read header");
        rd(8'h04, "R1 id byte 0");
        rd(8'h23, "R5 id byte 1");
        ev_stop();

        // R2 / R10: 8-bit wrap
        set_ofs(16'h00FF, 0, "R2 offset 0xFF");
        ev_start(1);
        hdr(1, 1, "R2 read header");
        rd(8'h00, "R10 unimplemented 0xFF");
        rd(8'h04, "R2 wrap to 0x00");
        ev_stop();

        // R6: read without offset continues at 0x01
        ev_start(0);
        hdr(1, 1, "R6 bare read header");
        rd(8'h23, "R6 continue from pointer");
        ev_stop();

        // R5: id read-only
        wr_reg(16'h0000, 0, 8'h55, "R5 write id");
        rd_reg(16'h0000, 0, 8'h04, "R5 id unchanged");

        // R10: unimplemented ignores writes
        wr_reg(16'h0020, 0, 8'hAA, "R10 write unimpl");
        rd_reg(16'h0020, 0, 8'h00, "R10 unimpl reads zero");

        // R3: switch to two-byte, effective at next start
        wr_reg(16'h0030, 0, 8'h04, "R3 set mode bit");
        rd_reg(16'h0030, 1, 8'h04, "R3 ctrl at 0x0030 two-byte");

        // R4: two-byte read of identification
        set_ofs(16'h0000, 1, "R4 offset 0x0000");
        ev_start(1);
        hdr(1, 1, "R4 read header");
        rd(8'h04, "R4 id0 two-byte");
        rd(8'h23, "R4 id1 two-byte");
        ev_stop();

        // R4: extended register
        set_ofs(16'h0300, 1, "R4 offset 0x0300");
        wr(8'h5A, 1, "R4 data 0x0300");
        wr(8'h77, 1, "R4 data 0x0301");
        ev_stop();
        set_ofs(16'h0300, 1, "R4 offset 0x0300 rd");
        ev_start(1);
        hdr(1, 1, "R4 read header");
        rd(8'h5A, "R4 ext readback");
        rd(8'h00, "R10 0x0301 unimpl");
        ev_stop();

        // R7: 16-bit wrap
        set_ofs(16'hFFFF, 1, "R7 offset 0xFFFF");
        ev_start(1);
        hdr(1, 1, "R7 read header");
        rd(8'h00, "R7 0xFFFF reads zero");
        rd(8'h04, "R7 wrap to 0x0000");
        ev_stop();

        // R8: locked write discarded
        wr_reg(16'h0040, 1, 8'h11, "R8 locked write acked");
        rd_reg(16'h0040, 1, 8'h00, "R8 locked write discarded");

        // R9: broken sequence stays locked
        wr_reg(16'h0037, 1, 8'h73, "R9 key A");
        wr_reg(16'h0037, 1, 8'h11, "R9 wrong key");
        wr_reg(16'h0037, 1, 8'h94, "R9 key B out of order");
        wr_reg(16'h0040, 1, 8'h22, "R9 write still locked");
        rd_reg(16'h0040, 1, 8'h00, "R9 broken sequence locked");

        // R9: correct sequence unlocks
        wr_reg(16'h0037, 1, 8'h73, "R9 key A");
        wr_reg(16'h0037, 1, 8'h94, "R9 key B");
        rd_reg(16'h0037, 1, 8'h00, "R9 key register reads zero");
        set_ofs(16'h0040, 1, "R9 unlocked offset");
        wr(8'h33, 1, "R9 data 0x40");
        wr(8'h44, 1, "R9 data 0x41");
        ev_stop();
        set_ofs(16'h0040, 1, "R9 readback offset");
        ev_start(1);
        hdr(1, 1, "R9 read header");
        rd(8'h33, "R9 unlocked 0x40");
        rd(8'h44, "R9 unlocked 0x41 auto-inc");
        ev_stop();
        wr_reg(16'h006F, 1, 8'h66, "R9 top of region");
        rd_reg(16'h006F, 1, 8'h66, "R9 0x6F writable");
        wr_reg(16'h0070, 1, 8'h99, "R10 just past region");
        rd_reg(16'h0070, 1, 8'h00, "R10 0x70 unimpl");

        // R3: back to one-byte mode
        wr_reg(16'h0030, 1, 8'h04 & 8'hFB, "R3 clear mode bit");
        rd_reg(16'h0030, 0, 8'h00, "R3 ctrl at 0x30 one-byte");
        rd_reg(16'h0040, 0, 8'h33, "R3 one-byte reaches 0x40");

        // R11: foreign header ignored
        ev_start(0);
        hdr(0, 0, "R11 foreign header nack");
        wr(8'h40, 0, "R11 foreign byte nack");
        wr(8'h99, 0, "R11 foreign data nack");
        ev_stop();
        rd_reg(16'h0040, 0, 8'h33, "R11 foreign write discarded");

        repeat (3) @(negedge clk);
        check("R12 all acks seen", 8'(q_ack.size()), 8'h0);
        check("R12 all reads seen", 8'(q_rd.size()), 8'h0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule